// File: doc/BRIEF.md
# Dual-Path Alignment Serial Control Register

This block is the digital control front end of a two-path RF alignment stage. A host shifts a control word in over a three-wire serial link: a data line, a shift clock and a separate load strobe. The block runs on a local system clock. It passes each external line through a synchronizer and detects rising edges in the system-clock domain. The serial chain is a long shift register. Its oldest stage drives a chain output, so several of these blocks can be cascaded. A load edge copies the sixteen newest stages into the output registers. The carrier path and the peaking path each receive a 5-bit attenuation code and a 3-bit phase code.

Until the first load edge after reset, the outputs show a preset chosen by a strap input: all codes zero, or all codes at their maximum. A disable input forces both paths to zero attenuation and zero phase, and freezes the serial chain and the output registers while it is high. The analog attenuators and phase shifters that consume the codes are outside this block.

Top module: `dpath_align_ctrl`

## Requirements
- R1: A rising edge of `ser_clk` shifts `ser_data` into the chain. The newest bit enters stage 0 and every other stage moves one place toward the chain output. An edge first sampled high at system-clock edge n takes effect at edge n+2, using the data value sampled at edge n.
- R2: `ser_chain_out` is always driven with the oldest stage of the SR_LEN-stage chain. A bit therefore reaches `ser_chain_out` after SR_LEN shift edges.
- R3: A rising edge of `load_clk` copies chain stages 15..0 into the outputs. Stages 15..8 go to the carrier path and stages 7..0 go to the peaking path. Within each byte, bits 7..3 are the attenuation code and bits 2..0 are the phase code. Stage 0 is the last bit received. The outputs change only on a load edge, a disable change or, before the first load, a strap change.
- R4: After reset and before the first load edge, both paths show the preset. With `strap_max` low, all codes are 0. With `strap_max` high, the attenuation codes are 31 and the phase codes are 7.
- R5: Once a load edge has occurred, `strap_max` has no effect on the outputs.
- R6: While `ctl_disable` is high, all four code outputs read 0.
- R7: While `ctl_disable` is high, shift edges and load edges are ignored. Both the chain contents and the latched word are left unchanged.
- R8: When `ctl_disable` returns low, the outputs show the last latched word. If no load edge has occurred since reset, they show the strap preset.
- R9: Synchronous reset clears the chain, so `ser_chain_out` reads 0. It also returns the outputs to the preset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on shift-clock rising edges |
| load_clk | input | 1 | Load strobe, rising edge copies the control field |
| ctl_disable | input | 1 | High forces the zero state and freezes serial activity |
| strap_max | input | 1 | Preset select before the first load: 1 = maximum codes, 0 = zero codes |
| ser_chain_out | output | 1 | Oldest chain stage, for cascading |
| carrier_att | output | 5 | Carrier-path attenuation code |
| carrier_phase | output | 3 | Carrier-path phase code |
| peak_att | output | 5 | Peaking-path attenuation code |
| peak_phase | output | 3 | Peaking-path phase code |

## Verification
The bench uses the default parameters: a 32-stage chain and two synchronizer stages. With this chain length, a marker bit can be walked all the way to the chain output and then out of it. With this synchronizer depth, the two-cycle shift latency and the three-cycle window used by the disable checks are fixed and short. A queue-based model follows every system-clock edge. On top of that, directed words cover the all-zero and all-one codes, a lone least significant bit, and a disable window that contains both shift and load activity. They also cover re-enabling before any load has occurred.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int unsigned ATT_W   = 5;
    localparam int unsigned PH_W    = 3;
    localparam int unsigned FIELD_W = ATT_W + PH_W;

    // One RF path: attenuation in the upper bits, phase in the lower bits.
    typedef struct packed {
        logic [ATT_W-1:0] att;
        logic [PH_W-1:0]  ph;
    } path_cfg_t;

    // Full control field: carrier byte first (older), peaking byte last.
    typedef struct packed {
        path_cfg_t carrier;
        path_cfg_t peak;
    } ctrl_word_t;

    localparam int unsigned CTRL_W = $bits(ctrl_word_t);

    function automatic ctrl_word_t preset_word(input logic hi);
        ctrl_word_t w;
        w = hi ? '1 : '0;
        return w;
    endfunction

    function automatic ctrl_word_t zero_word();
        return '0;
    endfunction

endpackage

// File: rtl/dpa_sync.sv
module dpa_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign level = stg[STAGES-1];
endmodule

// File: rtl/dpa_rise.sv
module dpa_rise #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= level;
    end

    assign rise = level & ~prev;
endmodule

// File: rtl/dpa_shift_chain.sv
module dpa_shift_chain #(
    parameter int unsigned LEN    = 32,
    parameter int unsigned HEAD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              din,
    output logic [HEAD_W-1:0] head,
    output logic              tail
);
    logic [LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)       chain <= '0;
        else if (step) chain <= {chain[LEN-2:0], din};
    end

    assign head = chain[HEAD_W-1:0];
    assign tail = chain[LEN-1];
endmodule

// File: rtl/dpa_ctrl_hold.sv
module dpa_ctrl_hold
    import dpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  ctrl_word_t word_in,
    input  logic       strap_hi,
    input  logic       force_zero,
    output ctrl_word_t word_out,
    output logic       have_word
);
    ctrl_word_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= zero_word();
            have_word <= 1'b0;
        end else if (capture) begin
            held      <= word_in;
            have_word <= 1'b1;
        end
    end

    always_comb begin
        if (force_zero)     word_out = zero_word();
        else if (have_word) word_out = held;
        else                word_out = preset_word(strap_hi);
    end
endmodule

// File: rtl/dpath_align_ctrl.sv
module dpath_align_ctrl
    import dpa_pkg::*;
#(
    parameter int unsigned SR_LEN      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             load_clk,
    input  logic             ctl_disable,
    input  logic             strap_max,
    output logic             ser_chain_out,
    output logic [ATT_W-1:0] carrier_att,
    output logic [PH_W-1:0]  carrier_phase,
    output logic [ATT_W-1:0] peak_att,
    output logic [PH_W-1:0]  peak_phase
);
    // Synchronized vector layout: {disable, data, load, shift}
    localparam int unsigned N_SYNC = 4;
    localparam int unsigned N_EDGE = 2;

    logic [N_SYNC-1:0] sync_lvl;
    logic [N_EDGE-1:0] edge_rise;
    logic              dis_s;
    logic              data_s;
    logic              shift_go;
    logic              load_go;
    ctrl_word_t        head_word;
    logic [CTRL_W-1:0] head_bits;
    ctrl_word_t        out_word;
    logic              have_word;

    dpa_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ctl_disable, ser_data, load_clk, ser_clk}),
        .level    (sync_lvl)
    );

    dpa_rise #(.W(N_EDGE)) u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (sync_lvl[N_EDGE-1:0]),
        .rise  (edge_rise)
    );

    assign dis_s    = sync_lvl[3];
    assign data_s   = sync_lvl[2];
    assign shift_go = edge_rise[0] & ~dis_s;
    assign load_go  = edge_rise[1] & ~dis_s;

    dpa_shift_chain #(.LEN(SR_LEN), .HEAD_W(CTRL_W)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .step (shift_go),
        .din  (data_s),
        .head (head_bits),
        .tail (ser_chain_out)
    );

    assign head_word = ctrl_word_t'(head_bits);

    dpa_ctrl_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .capture    (load_go),
        .word_in    (head_word),
        .strap_hi   (strap_max),
        .force_zero (dis_s),
        .word_out   (out_word),
        .have_word  (have_word)
    );

    assign carrier_att   = out_word.carrier.att;
    assign carrier_phase = out_word.carrier.ph;
    assign peak_att      = out_word.peak.att;
    assign peak_phase    = out_word.peak.ph;
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker (
    input logic        clk,
    input logic        rst,
    input logic        ser_clk,
    input logic        load_clk,
    input logic        ctl_disable,
    input logic        strap_max,
    input logic        ser_chain_out,
    input logic [15:0] codes,
    input logic        have_word
);
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    AST_DISABLE_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2 && $past(ctl_disable, 2)) |-> (codes == 16'h0000)); // R6

    AST_CHAIN_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 4 && !$past(ser_clk, 3)) |-> $stable(ser_chain_out)); // R2

    AST_DISABLE_FREEZES_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 4 && $past(ctl_disable, 3)) |-> $stable(ser_chain_out)); // R7

    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 4 && !$past(load_clk, 3)
         && ($past(ctl_disable, 2) == $past(ctl_disable, 3))
         && $stable(strap_max)) |-> $stable(codes)); // R3

    AST_PRESET_MAX: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2 && !have_word && !$past(ctl_disable, 2) && strap_max)
        |-> (codes == 16'hFFFF)); // R4
endmodule

bind dpath_align_ctrl dpa_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .ser_clk       (ser_clk),
    .load_clk      (load_clk),
    .ctl_disable   (ctl_disable),
    .strap_max     (strap_max),
    .ser_chain_out (ser_chain_out),
    .codes         ({carrier_att, carrier_phase, peak_att, peak_phase}),
    .have_word     (have_word)
);

// File: tb/tb_dpath_align_ctrl.sv
`timescale 1ns/1ps
module tb_dpath_align_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic load_clk = 1'b0;
    logic ctl_disable = 1'b0;
    logic strap_max = 1'b1;
    logic ser_chain_out;
    logic [4:0] carrier_att;
    logic [2:0] carrier_phase;
    logic [4:0] peak_att;
    logic [2:0] peak_phase;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    dpath_align_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .ser_clk       (ser_clk),
        .ser_data      (ser_data),
        .load_clk      (load_clk),
        .ctl_disable   (ctl_disable),
        .strap_max     (strap_max),
        .ser_chain_out (ser_chain_out),
        .carrier_att   (carrier_att),
        .carrier_phase (carrier_phase),
        .peak_att      (peak_att),
        .peak_phase    (peak_phase)
    );

    function automatic logic [15:0] codes();
        return {carrier_att, carrier_phase, peak_att, peak_phase};
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          q_sc[$];
    bit          q_sd[$];
    bit          q_lc[$];
    bit          q_dis[$];
    logic [31:0] m_chain;
    logic [15:0] m_word;
    bit          m_have;

    task automatic clear_hist();
        q_sc = {0, 0, 0, 0};
        q_sd = {0, 0, 0, 0};
        q_lc = {0, 0, 0, 0};
        q_dis = {0, 0, 0, 0};
    endtask

    initial clear_hist();

    always @(posedge clk) begin
        logic [15:0] exp_codes;
        if (rst) begin
            clear_hist();
            m_chain = '0;
            m_word  = '0;
            m_have  = 0;
        end else begin
            q_sc.push_front(ser_clk);      void'(q_sc.pop_back());
            q_sd.push_front(ser_data);     void'(q_sd.pop_back());
            q_lc.push_front(load_clk);     void'(q_lc.pop_back());
            q_dis.push_front(ctl_disable); void'(q_dis.pop_back());
            if (q_lc[2] && !q_lc[3] && !q_dis[2]) begin
                m_word = m_chain[15:0];
                m_have = 1;
            end
            if (q_sc[2] && !q_sc[3] && !q_dis[2])
                m_chain = {m_chain[30:0], q_sd[2]};
        end
        #1;
        if (q_dis[1])    exp_codes = 16'h0000;
        else if (m_have) exp_codes = m_word;
        else             exp_codes = strap_max ? 16'hFFFF : 16'h0000;
        n_checks++;
        if (ser_chain_out !== m_chain[31] || codes() !== exp_codes) begin
            n_fails++;
            $display("FAIL R1 R2 R3 cycle model: chain_out=%0b codes=%h expected chain_out=%0b codes=%h",
                     ser_chain_out, codes(), m_chain[31], exp_codes);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        cyc(1);
        ser_clk = 1'b1;
        cyc(2);
        ser_clk = 1'b0;
        cyc(2);
    endtask

    task automatic send_word(logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        load_clk = 1'b1;
        cyc(2);
        load_clk = 1'b0;
        cyc(4);
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        // R9 / R4: reset state with strap high
        check("R9 chain_out after reset", {15'd0, ser_chain_out}, 16'h0000);
        check("R4 preset max", codes(), 16'hFFFF);
        strap_max = 1'b0;
        cyc(1);
        check("R4 preset zero", codes(), 16'h0000);

        // R3: field mapping
        send_word(16'hA53C);
        check("R3 no change before load", codes(), 16'h0000);
        pulse_load();
        check("R3 carrier att", {11'd0, carrier_att}, 16'd20);
        check("R3 carrier phase", {13'd0, carrier_phase}, 16'd5);
        check("R3 peak att", {11'd0, peak_att}, 16'd7);
        check("R3 peak phase", {13'd0, peak_phase}, 16'd4);
        strap_max = 1'b1;
        cyc(2);
        check("R5 strap ignored after load", codes(), 16'hA53C);

        // R2: marker walks through all 32 stages
        send_bit(1'b1);
        for (int i = 0; i < 31; i++) send_bit(1'b0);
        check("R2 marker at chain output", {15'd0, ser_chain_out}, 16'h0001);
        send_bit(1'b0);
        check("R2 marker shifted out", {15'd0, ser_chain_out}, 16'h0000);
        check("R3 shifting alone leaves codes", codes(), 16'hA53C);

        // R6 / R7 / R8: disable window
        ctl_disable = 1'b1;
        cyc(4);
        check("R6 disabled codes", codes(), 16'h0000);
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        pulse_load();
        check("R6 still zero after load attempt", codes(), 16'h0000);
        check("R7 chain output frozen", {15'd0, ser_chain_out}, 16'h0000);
        ctl_disable = 1'b0;
        cyc(4);
        check("R8 last latched word restored", codes(), 16'hA53C);
        pulse_load();
        check("R7 shifts ignored while disabled", codes(), 16'h0000);

        // R3 / R1: extremes and bit order
        send_word(16'hFFFF);
        pulse_load();
        check("R3 all-ones word", codes(), 16'hFFFF);
        send_word(16'h0001);
        pulse_load();
        check("R1 last bit lands in peak phase lsb", codes(), 16'h0001);

        // R8: re-enable before any load shows preset
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        ctl_disable = 1'b1;
        cyc(4);
        check("R6 disabled before first load", codes(), 16'h0000);
        ctl_disable = 1'b0;
        cyc(4);
        check("R8 preset after re-enable", codes(), 16'hFFFF);
        strap_max = 1'b0;
        cyc(1);
        check("R4 strap follows before load", codes(), 16'h0000);

        cyc(4);
        finish_run();
    end

endmodule